// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Aggregator

The block gathers 32 asynchronous interrupt request lines into one upstream interrupt signal. Each line goes through a two-flop synchroniser. It is then treated in one of four trigger modes: active-high level, active-low level, rising edge or falling edge. A pair of configuration bits picks the mode, one bit in the polarity register and one in the edge-select register.

Level lines report the current corrected level. Edge events and software-raised requests are held in a sticky bit until software acknowledges them through a write-one-to-clear register. The upstream output is asserted while any line has both its status bit and its enable bit set. Software reaches the registers through a plain 32-bit read/write port with a byte address. Reads are combinational and writes take effect on the clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable (0x04), polarity (0x10) and edge-select (0x14) registers read 0, every sticky bit is 0 and `irq_out` is 0.
- R2: Enable, polarity and edge-select are read/write and return the last value written to them.
- R3: With edge-select bit 0, a line's status bit (0x00, bit n for line n) equals its synchronised input when polarity is 1 and the inverted input when polarity is 0. It follows the input two clock edges after a change.
- R4: With edge-select bit 1, a rising edge (polarity 1) or falling edge (polarity 0) of the synchronised input sets the line's status bit, which stays 1 after the input returns.
- R5: Writing 1 to bit n of the clear register (0x0C) clears line n's sticky bit, and 0 bits have no effect. A level line whose level is still active keeps reading 1.
- R6: When an edge event and a clear of the same line meet in one cycle, the status bit ends up 1.
- R7: Writing 1 to bit n of the set register (0x08) makes line n's status bit 1 and keeps it there until cleared.
- R8: `irq_out` is 1 exactly when some line has both status and enable bits set.
- R9: Reads of the set and clear offsets and of any undefined offset return 0. Writes to undefined offsets and to the status offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw interrupt request lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined upstream interrupt |

## Verification
The assertions watch four things on every cycle: that the output never fires with all enables off, that an unacknowledged sticky bit never drops, that an edge or set always lands in the sticky state (even against a clear), and that configuration writes either stick or, at undefined offsets, leave everything unchanged. The bench scenarios cover the rest. They show the level status tracking the input with the right polarity and the synchroniser latency, both edge directions, the reset values, and the read-zero behaviour of write-only and unmapped offsets, all by comparing register reads and `irq_out` against values computed from the requirements.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'('h14);

  logic [31:0] meta_q, sync_q, prev_q;
  logic [31:0] en_q, pol_q, edge_q, sticky_q;
  logic [31:0] set_vec, clr_vec, edge_hit, level_act, status;
  logic        known_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= irq_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign set_vec   = (reg_wr && reg_addr == A_SET) ? reg_wdata : '0;
  assign clr_vec   = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
  assign level_act = ~(sync_q ^ pol_q);
  assign edge_hit  = edge_q & ((pol_q & sync_q & ~prev_q) | (~pol_q & ~sync_q & prev_q));
  assign status    = sticky_q | (~edge_q & level_act);
  assign irq_out   = |(status & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
      sticky_q <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_vec) | edge_hit | set_vec;
      if (reg_wr) begin
        case (reg_addr)
          A_EN:    en_q   <= reg_wdata;
          A_POL:   pol_q  <= reg_wdata;
          A_EDGE:  edge_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign known_addr = reg_addr inside {A_STAT, A_EN, A_SET, A_CLR, A_POL, A_EDGE};

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status;
      A_EN:    reg_rdata = en_q;
      A_POL:   reg_rdata = pol_q;
      A_EDGE:  reg_rdata = edge_q;
      default: reg_rdata = '0;
    endcase
  end

  // R8
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

  // R4 R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sticky_q) & ~$past(clr_vec)) & ~sticky_q) == '0);

  // R6
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_hit) & ~sticky_q) == '0);

  // R7
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_vec) & ~sticky_q) == '0);

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN) |=> (en_q == $past(reg_wdata)));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !known_addr) |=> ($stable(en_q) && $stable(pol_q) && $stable(edge_q) && $stable(sticky_q)));

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 enable", d, 0);
    rd(8'h10, d); chk("R1 polarity", d, 0);
    rd(8'h14, d); chk("R1 edge", d, 0);
    chk("R1 irq_out", {31'd0, irq_out}, 0);
    rd(8'h00, d); chk("R3 active-low idle", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); chk("R2 enable", d, 32'hA5A5_0F0F);
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); chk("R2 polarity", d, 32'h1234_5678);
    wr(8'h14, 32'h8000_0001); rd(8'h14, d); chk("R2 edge", d, 32'h8000_0001);
    wr(8'h04, 0); wr(8'h14, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    logic [31:0] pol = 32'h0000_FFFF;
    wr(8'h10, pol);
    settle();
    @(negedge clk); irq_in = 32'h0001_00F0;
    @(negedge clk); #1;
    rd(8'h00, d); chk("R3 level after sync", d, ~(32'h0001_00F0 ^ pol));
    settle();
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R5 clear on active level", d, ~(32'h0001_00F0 ^ pol));
    @(negedge clk); irq_in = 32'h0000_0000;
    settle();
    rd(8'h00, d); chk("R3 level follows", d, ~pol);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); irq_in = 32'h0000_00FF;
    wr(8'h10, 32'hFFFF_FF00);
    wr(8'h14, 32'hFFFF_FFFF);
    settle();
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R4 quiet edge lines", d, 0);
    @(negedge clk); irq_in = 32'h0000_0300;
    settle();
    rd(8'h00, d); chk("R4 rise and fall", d, 32'h0000_03FF);
    @(negedge clk); irq_in = 32'h0000_00FF;
    settle();
    rd(8'h00, d); chk("R4 sticky after return", d, 32'h0000_03FF);
    wr(8'h0C, 32'h0000_0001);
    rd(8'h00, d); chk("R5 clear one bit", d, 32'h0000_03FE);
    wr(8'h0C, 32'h0000_0000);
    rd(8'h00, d); chk("R5 zero bits ignored", d, 32'h0000_03FE);
    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); irq_in = 32'h0000_08FF;
    @(posedge clk); @(posedge clk);
    wr(8'h0C, 32'h0000_0800);
    rd(8'h00, d); chk("R6 edge wins over clear", d, 32'h0000_0800);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(8'h08, 32'h8000_0000);
    settle();
    rd(8'h00, d); chk("R7 software set", d, 32'h8000_0000);
    wr(8'h04, 32'h0000_0001);
    @(negedge clk); #1 chk("R8 no enabled line", {31'd0, irq_out}, 0);
    wr(8'h04, 32'h8000_0000);
    @(negedge clk); #1 chk("R8 enabled line", {31'd0, irq_out}, 1);
    wr(8'h0C, 32'h8000_0000);
    @(negedge clk); #1 chk("R8 after clear", {31'd0, irq_out}, 0);
  endtask

  task automatic t_stray();
    logic [31:0] d;
    wr(8'h08, 32'h0000_0004);
    rd(8'h08, d); chk("R9 set reads 0", d, 0);
    rd(8'h0C, d); chk("R9 clear reads 0", d, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R9 undefined reads 0", d, 0);
    rd(8'h04, d); chk("R9 enable untouched", d, 32'h8000_0000);
    rd(8'h14, d); chk("R9 edge untouched", d, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); chk("R9 status write ignored", d, 32'h0000_0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_set();
    t_stray();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule